// File: doc/BRIEF.md
# ATA device status, completion timer and interrupt

This block keeps the device-side status, error and device-control state of a disk or packet-type ATA device. It also drives the device's interrupt line to the host. A command engine elsewhere raises a completion request, which is either normal or fast, and may carry error bits and a flag that says data is waiting. The block then goes busy at once. It counts a short delay on a single-cycle tick input, and when the delay runs out it drops busy, raises data-request if data is waiting, and raises the interrupt unless the host has masked it.

The host reaches the block through register read and write strobes with a 3-bit address. The address map is:

| Address | Read | Write |
|---|---|---|
| 0 | error | ignored |
| 1 | count | count |
| 2 | sector | sector |
| 3 | cylinder low | cylinder low |
| 4 | cylinder high | cylinder high |
| 5 | select | select |
| 6 | status | command |
| 7 | alternate status | device control |

The count, sector and cylinder registers each keep the byte written before the current one. The host can read that older byte back through a device-control select bit. A rising edge on the soft-reset bit of device control loads the power-on signature, and the signature depends on the device type. Read data is registered and appears one clock after the read strobe.

Top module: `ata_status_ctl`

## Requirements
- R1: After reset, count and sector read 0x01 and error reads 0x01. Cylinder low and high read 0x00 and 0x00 for a disk, and 0x14 and 0xEB for a packet device. The interrupt is low.
- R2: A completion request sets status bit 7 (busy) and clears bit 3 (data-request) at the next clock edge.
- R3: Busy clears on the second tick after a normal request, or on the first tick after a fast request. At that edge bit 3 takes the data-pending value that was latched with the request.
- R4: At the edge where busy clears, the interrupt goes high unless device-control bit 1 is set. If that bit is set, the interrupt stays low.
- R5: A read of address 6 (status) clears the interrupt. A read of address 7 (alternate status) returns the same value and leaves the interrupt unchanged.
- R6: While busy is set, a read of any address 0 to 5 returns the status value and acts as a status read.
- R7: When device-control bit 7 is set, reads of addresses 1 to 4 return the byte written before the current one. A write to any address other than 7 clears bit 7.
- R8: A write to address 7 that takes bit 2 from 0 to 1 loads the R1 signature into addresses 1 to 4. It also clears status bits 0 and 3, cancels busy, sets error to 0x01 and clears the packet command-seen flag. A write with bit 2 already at 1 loads nothing.
- R9: A write to address 6 (command) clears status bits 0 and 3 and zeroes the error register.
- R10: A disk sets status bit 6 (ready) and bit 4 (seek done) on every status read. A packet device sets them only after a command write made since the last reset.
- R11: Nonzero error bits on a completion request are ORed into the error register and set status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | 8 | Write data |
| tick | input | 1 | Delay tick, one cycle wide |
| done_req | input | 1 | Completion request |
| done_fast | input | 1 | Use the short delay for this request |
| done_drq | input | 1 | Data is pending at completion |
| done_err | input | 8 | Error bits to merge with this request |
| host_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt to the host |

## Verification
The bench builds two instances with the default delays of 2 and 1 ticks: one as a disk and one as a packet device, and both receive the same stimulus. With delays this short, the bench can place every tick and observe busy, data-request and the interrupt edge by edge. Because both instances see identical stimulus, the only differences in their outputs come from the signatures and from when the ready bits appear. A behavioural model of the busy delay and the interrupt is compared against both interrupt lines on every clock.

// File: rtl/ata_stat_pkg.sv
package ata_stat_pkg;
  localparam logic [2:0] A_ERR = 3'd0;
  localparam logic [2:0] A_CNT = 3'd1;
  localparam logic [2:0] A_CHI = 3'd4;
  localparam logic [2:0] A_SEL = 3'd5;
  localparam logic [2:0] A_CMD = 3'd6;
  localparam logic [2:0] A_CTL = 3'd7;

  localparam int CTL_NIEN = 1;
  localparam int CTL_SRST = 2;
  localparam int CTL_PREV = 7;

  localparam logic [7:0] ERR_SIG = 8'h01;

  // Power-on value of task-file slot idx (0 count, 1 sector, 2 cyl low, 3 cyl high)
  function automatic logic [7:0] sig_val(input int idx, input bit is_pkt);
    case (idx)
      0, 1:    sig_val = 8'h01;
      2:       sig_val = is_pkt ? 8'h14 : 8'h00;
      3:       sig_val = is_pkt ? 8'hEB : 8'h00;
      default: sig_val = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/ata_done_timer.sv
module ata_done_timer #(
  parameter int SLOW_DELAY = 2,
  parameter int FAST_DELAY = 1,
  localparam int DLY_W = $clog2(SLOW_DELAY + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic cancel,
  input  logic start,
  input  logic fast,
  input  logic tick,
  output logic busy,
  output logic expire
);
  logic [DLY_W-1:0] cnt_q;

  assign busy   = (cnt_q != '0);
  assign expire = tick && (cnt_q == DLY_W'(1)) && !start && !cancel;

  always_ff @(posedge clk) begin
    if (rst || cancel)
      cnt_q <= '0;
    else if (start)
      cnt_q <= fast ? DLY_W'(FAST_DELAY) : DLY_W'(SLOW_DELAY);
    else if (tick && busy)
      cnt_q <= cnt_q - DLY_W'(1);
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= DLY_W'(SLOW_DELAY)); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    start && !cancel |=> busy); // R2
endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
  import ata_stat_pkg::*;
#(
  parameter int NUM_TF = 4,
  parameter bit IS_PACKET = 1'b0,
  parameter int ADDR_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sig_load,
  input  logic                   wr,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wdata,
  output logic [NUM_TF-1:0][7:0] cur,
  output logic [NUM_TF-1:0][7:0] prev
);
  for (genvar i = 0; i < NUM_TF; i++) begin : g_tf
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i + 1);
    always_ff @(posedge clk) begin
      if (rst) begin
        cur[i]  <= sig_val(i, IS_PACKET);
        prev[i] <= 8'h00;
      end else if (sig_load) begin
        cur[i]  <= sig_val(i, IS_PACKET);
      end else if (wr && addr == MY_ADDR) begin
        prev[i] <= cur[i];
        cur[i]  <= wdata;
      end
    end
  end

  AST_SIG_COUNT: assert property (@(posedge clk) disable iff (rst)
    sig_load |=> cur[0] == 8'h01); // R8
endmodule

// File: rtl/ata_rd_mux.sv
module ata_rd_mux
  import ata_stat_pkg::*;
#(
  parameter int NUM_TF = 4,
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   sel_prev,
  input  logic [7:0]             err,
  input  logic [7:0]             sel,
  input  logic [7:0]             stat,
  input  logic [NUM_TF-1:0][7:0] cur,
  input  logic [NUM_TF-1:0][7:0] prev,
  output logic [7:0]             data
);
  always_comb begin
    data = 8'h00;
    if (addr == A_ERR)
      data = err;
    else if (addr >= A_CNT && addr <= A_CHI)
      data = sel_prev ? prev[addr - A_CNT] : cur[addr - A_CNT];
    else if (addr == A_SEL)
      data = sel;
    else
      data = stat;
  end
endmodule

// File: rtl/ata_status_ctl.sv
module ata_status_ctl
  import ata_stat_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int NUM_TF = 4,
  parameter int SLOW_DELAY = 2,
  parameter int FAST_DELAY = 1,
  parameter bit IS_PACKET = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              tick,
  input  logic              done_req,
  input  logic              done_fast,
  input  logic              done_drq,
  input  logic [7:0]        done_err,
  output logic [7:0]        host_rdata,
  output logic              irq
);
  logic [7:0] ctl_q, err_q, sel_q, err_base, stat_val, mux_out;
  logic stat_err_q, drq_q, pend_q, seen_q;
  logic busy, expire, srst_edge, cmd_wr, stat_rd, rdy;
  logic [ADDR_W-1:0] eff_addr;
  logic [NUM_TF-1:0][7:0] tf_cur, tf_prev;

  assign srst_edge = host_wr && host_addr == A_CTL && host_wdata[CTL_SRST] && !ctl_q[CTL_SRST];
  assign cmd_wr    = host_wr && host_addr == A_CMD;
  assign eff_addr  = (busy && host_addr < A_CMD) ? A_CMD : host_addr;
  assign stat_rd   = host_rd && eff_addr == A_CMD;
  assign rdy       = IS_PACKET ? seen_q : 1'b1;
  assign stat_val  = {busy, rdy, 1'b0, rdy, drq_q, 2'b00, stat_err_q};
  assign err_base  = cmd_wr ? 8'h00 : err_q;

  ata_done_timer #(.SLOW_DELAY(SLOW_DELAY), .FAST_DELAY(FAST_DELAY)) u_timer (
    .clk(clk), .rst(rst), .cancel(srst_edge), .start(done_req), .fast(done_fast),
    .tick(tick), .busy(busy), .expire(expire));

  ata_tf_regs #(.NUM_TF(NUM_TF), .IS_PACKET(IS_PACKET), .ADDR_W(ADDR_W)) u_tf (
    .clk(clk), .rst(rst), .sig_load(srst_edge), .wr(host_wr), .addr(host_addr),
    .wdata(host_wdata), .cur(tf_cur), .prev(tf_prev));

  ata_rd_mux #(.NUM_TF(NUM_TF), .ADDR_W(ADDR_W)) u_mux (
    .addr(eff_addr), .sel_prev(ctl_q[CTL_PREV]), .err(err_q), .sel(sel_q),
    .stat(stat_val), .cur(tf_cur), .prev(tf_prev), .data(mux_out));

  always_ff @(posedge clk) begin
    if (rst)
      ctl_q <= 8'h00;
    else if (host_wr) begin
      if (host_addr == A_CTL) ctl_q <= host_wdata;
      else                    ctl_q[CTL_PREV] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                             sel_q <= 8'h00;
    else if (host_wr && host_addr == A_SEL) sel_q <= host_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || srst_edge) begin
      err_q      <= ERR_SIG;
      stat_err_q <= 1'b0;
      drq_q      <= 1'b0;
      pend_q     <= 1'b0;
      seen_q     <= 1'b0;
    end else begin
      if (cmd_wr) begin
        err_q      <= 8'h00;
        stat_err_q <= 1'b0;
        drq_q      <= 1'b0;
        seen_q     <= 1'b1;
      end
      if (done_req) begin
        drq_q  <= 1'b0;
        pend_q <= done_drq;
        if (done_err != 8'h00) begin
          err_q      <= err_base | done_err;
          stat_err_q <= 1'b1;
        end
      end else if (expire) begin
        drq_q <= pend_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                            irq <= 1'b0;
    else if (expire && !ctl_q[CTL_NIEN]) irq <= 1'b1;
    else if (stat_rd)                   irq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= 8'h00;
    else if (host_rd) host_rdata <= mux_out;
  end

  AST_BSY_NO_DRQ: assert property (@(posedge clk) disable iff (rst)
    busy |-> !drq_q); // R2
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    expire && !ctl_q[CTL_NIEN] |=> irq); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    expire && ctl_q[CTL_NIEN] && !stat_rd |=> irq == $past(irq)); // R4
  AST_ALT_KEEP: assert property (@(posedge clk) disable iff (rst)
    host_rd && host_addr == A_CTL && !expire |=> irq == $past(irq)); // R5
  AST_PREV_CLEAR: assert property (@(posedge clk) disable iff (rst)
    host_wr && host_addr != A_CTL |=> !ctl_q[CTL_PREV]); // R7
  AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cmd_wr && !done_req |=> err_q == 8'h00 && !stat_err_q); // R9
endmodule

// File: tb/ata_status_ctl_test.sv
module ata_status_ctl_test;
  logic clk = 1'b0, rst = 1'b1;
  logic host_wr = 0, host_rd = 0, tick = 0, done_req = 0, done_fast = 0, done_drq = 0;
  logic [2:0] host_addr = 0;
  logic [7:0] host_wdata = 0, done_err = 0;
  logic [7:0] rd_d, rd_p;
  logic irq_d, irq_p;
  int tests = 0, fails = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  ata_status_ctl #(.IS_PACKET(1'b0)) uut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .tick(tick), .done_req(done_req), .done_fast(done_fast),
    .done_drq(done_drq), .done_err(done_err), .host_rdata(rd_d), .irq(irq_d));

  ata_status_ctl #(.IS_PACKET(1'b1)) uut_pkt (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .tick(tick), .done_req(done_req), .done_fast(done_fast),
    .done_drq(done_drq), .done_err(done_err), .host_rdata(rd_p), .irq(irq_p));

  // behavioural model of busy delay and interrupt
  int m_cnt = 0;
  bit m_irq = 0;
  logic [7:0] m_ctl = 0;
  always @(posedge clk) begin
    bit clr, fire, srst;
    if (rst) begin
      m_cnt = 0; m_irq = 0; m_ctl = 0;
    end else begin
      clr  = host_rd && (host_addr == 6 || (m_cnt > 0 && host_addr < 6));
      srst = host_wr && host_addr == 7 && host_wdata[2] && !m_ctl[2];
      fire = 0;
      if (srst) m_cnt = 0;
      else if (done_req) m_cnt = done_fast ? 1 : 2;
      else if (tick && m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) fire = 1;
      end
      if (fire && !m_ctl[1]) m_irq = 1;
      else if (clr) m_irq = 0;
      if (host_wr) m_ctl = (host_addr == 7) ? host_wdata : (m_ctl & 8'h7f);
    end
  end

  always @(negedge clk) if (!rst && !done_flag) begin
    tests++;
    if (irq_d !== m_irq || irq_p !== m_irq) begin
      fails++;
      $display("FAIL R4/R5 model irq: disk=%b pkt=%b expected=%b", irq_d, irq_p, m_irq);
    end
  end

  task automatic chk(input string what, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h", what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a);
    host_rd = 1; host_addr = a;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic done(input bit fast, input bit drq, input logic [7:0] e);
    done_req = 1; done_fast = fast; done_drq = drq; done_err = e;
    @(negedge clk); done_req = 0; done_err = 0;
  endtask

  task automatic tk();
    tick = 1; @(negedge clk); tick = 0;
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst = 0;
        // R1 / R10 reset state
        rd(6); chk("R1 disk status", rd_d, 8'h50); chk("R10 pkt status before cmd", rd_p, 8'h00);
        rd(1); chk("R1 count", rd_d, 8'h01);
        rd(2); chk("R1 sector", rd_p, 8'h01);
        rd(3); chk("R1 disk cyl low", rd_d, 8'h00); chk("R1 pkt cyl low", rd_p, 8'h14);
        rd(4); chk("R1 disk cyl high", rd_d, 8'h00); chk("R1 pkt cyl high", rd_p, 8'hEB);
        rd(0); chk("R1 error", rd_d, 8'h01);
        chk("R1 irq low", {7'd0, irq_d}, 8'h00);
        // R7 previous-byte readback
        wr(1, 8'h22); wr(1, 8'h33); wr(7, 8'h80);
        rd(1); chk("R7 prev count", rd_d, 8'h22);
        wr(2, 8'h09);
        rd(1); chk("R7 cleared by write", rd_d, 8'h33);
        // R2 R3 R6 normal completion with data
        wr(6, 8'h20);
        rd(6); chk("R10 pkt status after cmd", rd_p, 8'h50);
        done(0, 1, 8'h00);
        rd(6); chk("R2 busy status", rd_d, 8'hD0);
        rd(1); chk("R6 busy read of count", rd_d, 8'hD0);
        tk();
        rd(7); chk("R3 still busy after one tick", rd_d, 8'hD0);
        tk();
        chk("R4 irq raised", {7'd0, irq_d}, 8'h01);
        rd(7); chk("R3 drq set alt status", rd_d, 8'h58);
        chk("R5 alt read keeps irq", {7'd0, irq_d}, 8'h01);
        rd(6); chk("R5 status read value", rd_d, 8'h58);
        chk("R5 status read clears irq", {7'd0, irq_d}, 8'h00);
        // R3 fast completion without data
        done(1, 0, 8'h00);
        tk();
        rd(7); chk("R3 fast done after one tick", rd_d, 8'h50);
        chk("R4 fast irq", {7'd0, irq_d}, 8'h01);
        rd(6);
        // R4 masked
        wr(7, 8'h02);
        done(0, 0, 8'h00); tk(); tk();
        chk("R4 masked irq", {7'd0, irq_d}, 8'h00);
        rd(6); chk("R4 masked status", rd_d, 8'h50);
        wr(7, 8'h00);
        // R11 error completion, R9 command clears
        done(0, 0, 8'h04);
        rd(6); chk("R11 busy with err", rd_d, 8'hD1);
        tk(); tk();
        rd(6); chk("R11 status err", rd_d, 8'h51);
        rd(0); chk("R11 error reg", rd_d, 8'h04);
        wr(6, 8'h20);
        rd(6); chk("R9 status after cmd", rd_d, 8'h50);
        rd(0); chk("R9 error cleared", rd_d, 8'h00);
        // R8 soft reset
        wr(1, 8'h77); wr(7, 8'h04);
        rd(1); chk("R8 count signature", rd_d, 8'h01);
        rd(0); chk("R8 error signature", rd_d, 8'h01);
        rd(6); chk("R8 disk status", rd_d, 8'h50); chk("R8 pkt status", rd_p, 8'h00);
        rd(4); chk("R8 pkt cyl high", rd_p, 8'hEB);
        wr(1, 8'h55); wr(7, 8'h04);
        rd(1); chk("R8 no reload without edge", rd_d, 8'h55);
        wr(7, 8'h00);
        // R8 cancel busy
        done(0, 0, 8'h00); wr(7, 8'h04);
        rd(7); chk("R8 reset cancels busy", rd_d, 8'h50);
        wr(7, 8'h00); wr(6, 8'h00);
        rd(6); chk("R10 pkt ready after cmd", rd_p, 8'h50);
        repeat (3) @(negedge clk);
      end
      begin
        repeat (5000) @(negedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule